// File: doc/BRIEF.md
# Multi-Lane Deskew Group Controller

This block decides when the elastic receive FIFOs of a set of serial lanes may start being read, so that data leaving them is lined up across the lanes. It sits beside the FIFOs, which are outside the block, and watches one single-cycle marker pulse per lane. Each pulse reports that the lane's FIFO has taken in a deskew marker character. A two-speed countdown runs for every lane group. When it finishes, one common read enable goes high for every enabled lane of that group.

Lanes are grouped as singles, adjacent pairs, quads, or all lanes of both quads together. A lane can be switched off without disturbing its partners. An alignment is made once only. It is repeated only after the resync input changes level.

Top module: `lane_deskew_group`

## Requirements
- R1: While reset is held and on the first sample after reset, every bit of `lane_rd_en` and `all_aligned` is 0.
- R2: A marker pulse sampled on clock edge E is latched. Starting at edge E+1, the group's counter, loaded with 18, counts down by 1 on each edge while only some of its enabled lanes have latched a marker. When a group has one enabled lane, a marker latched at E brings `lane_rd_en` high on edge E+9.
- R3: Once every enabled lane of the group has latched a marker (visible from the edge after the last one is sampled), the counter counts down by 2 per edge. A step of 2 taken from a value of 1 ends at 0. On the edge where the counter reaches 0, `lane_rd_en` rises together for all enabled lanes of the group.
- R4: `group_mode` encodes the grouping. 0 means each lane is alone. 1 means lanes 2k and 2k+1 form a pair. 2 means lanes 4q to 4q+3 form a quad. 3 means all eight lanes form one group.
- R5: Markers are held per lane, so a lane whose marker came early still counts toward the all-lanes condition, whatever order the markers arrive in.
- R6: A lane with `lane_en` low is no member of its group. Its marker is neither latched nor starts the count, the others never wait for it, and its `lane_rd_en` stays 0.
- R7: Once a group is aligned, later markers on its lanes have no effect and its `lane_rd_en` bits stay high.
- R8: Any level change on `resync_tgl`, sampled at edge E, clears every latched marker and returns every group to its start state. From edge E on, all of `lane_rd_en` is 0.
- R9: `group_mode` is taken only while every group is idle. A change made while any group is counting or aligned takes effect only after the next resync.
- R10: `all_aligned` is 1 exactly when at least one lane is enabled and every enabled lane has `lane_rd_en` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| marker_in | input | 8 | Per-lane marker-received pulse from the FIFO |
| lane_en | input | 8 | Per-lane enable; low means powered down and excluded |
| group_mode | input | 2 | Grouping select (0 single, 1 pair, 2 quad, 3 all) |
| resync_tgl | input | 1 | Resync request; each level change restarts alignment |
| lane_rd_en | output | 8 | Per-lane FIFO read enable |
| all_aligned | output | 1 | Every enabled lane is reading |

## Verification
The assertions assume that `lane_en` stays steady while a lane's read enable is high and that no resync edge happens in the same cycle, since either one may legally drop the enable. The timing bound on rising enables assumes that markers only come in after reset or a resync, so the full countdown always lies between. The stimulus keeps to this. It changes `lane_en` only while all groups are idle, separates resync toggles from marker pulses by at least one cycle, and runs one alignment at a time, so every rising enable can be matched against a single expected entry.

// File: rtl/lane_deskew_pkg.sv
package lane_deskew_pkg;

   typedef enum logic [1:0] {
      GRP_SINGLE = 2'd0,
      GRP_PAIR   = 2'd1,
      GRP_QUAD   = 2'd2,
      GRP_ALL    = 2'd3
   } grp_mode_e;

   typedef enum logic [1:0] {
      ST_IDLE      = 2'd0,
      ST_COUNT_ANY = 2'd1,
      ST_COUNT_ALL = 2'd2,
      ST_ALIGNED   = 2'd3
   } dsk_state_e;

   // Index of the lowest lane of the group a lane belongs to; that index
   // also names the group controller serving it.
   function automatic int unsigned grp_leader(int unsigned lane, grp_mode_e mode,
                                              int unsigned lanes_per_quad);
      case (mode)
         GRP_SINGLE: return lane;
         GRP_PAIR:   return (lane / 2) * 2;
         GRP_QUAD:   return (lane / lanes_per_quad) * lanes_per_quad;
         default:    return 0;
      endcase
   endfunction

endpackage

// File: rtl/dsk_marker_latch.sv
module dsk_marker_latch #(
   parameter int NUM_LANES = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 restart,
   input  logic [NUM_LANES-1:0] marker_in,
   input  logic [NUM_LANES-1:0] lane_en,
   output logic [NUM_LANES-1:0] seen_q
);

   // Markers of disabled lanes are dropped so a lane re-enabled later cannot
   // bring a stale marker into its group.
   always_ff @(posedge clk) begin
      if (!rst_n || restart) seen_q <= '0;
      else                   seen_q <= seen_q | (marker_in & lane_en);
   end

endmodule

// File: rtl/dsk_group_map.sv
module dsk_group_map
   import lane_deskew_pkg::*;
#(
   parameter int NUM_LANES      = 8,
   parameter int LANES_PER_QUAD = 4,
   localparam int IDX_W         = $clog2(NUM_LANES)
) (
   input  grp_mode_e                            mode,
   input  logic [NUM_LANES-1:0]                 lane_en,
   output logic [NUM_LANES-1:0][IDX_W-1:0]      lane_grp,
   output logic [NUM_LANES-1:0][NUM_LANES-1:0]  grp_members
);

   for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
      assign lane_grp[l] = IDX_W'(grp_leader(l, mode, LANES_PER_QUAD));
   end

   always_comb begin
      for (int g = 0; g < NUM_LANES; g++) begin
         for (int l = 0; l < NUM_LANES; l++) begin
            grp_members[g][l] = lane_en[l] &&
                                (grp_leader(l, mode, LANES_PER_QUAD) == g);
         end
      end
   end

endmodule

// File: rtl/dsk_group_ctrl.sv
module dsk_group_ctrl
   import lane_deskew_pkg::*;
#(
   parameter int NUM_LANES = 8,
   parameter int CNT_INIT  = 18,
   localparam int CNT_W    = $clog2(CNT_INIT + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 restart,
   input  logic [NUM_LANES-1:0] members,
   input  logic [NUM_LANES-1:0] seen,
   output dsk_state_e           state_o,
   output logic                 aligned_o
);

   dsk_state_e       st_q;
   logic [CNT_W-1:0] cnt_q;
   logic             any_seen;
   logic             all_seen;
   logic [CNT_W-1:0] step;
   logic [CNT_W-1:0] cnt_next;

   assign any_seen = |(seen & members);
   assign all_seen = (members != '0) && ((seen & members) == members);
   assign step     = all_seen ? CNT_W'(2) : CNT_W'(1);
   // Saturating decrement: a step of 2 from 1 lands on 0.
   assign cnt_next = (cnt_q > step) ? (cnt_q - step) : '0;

   always_ff @(posedge clk) begin
      if (!rst_n || restart) begin
         st_q  <= ST_IDLE;
         cnt_q <= CNT_W'(CNT_INIT);
      end else if (st_q != ST_ALIGNED && (st_q != ST_IDLE || any_seen)) begin
         cnt_q <= cnt_next;
         if (cnt_next == '0)  st_q <= ST_ALIGNED;
         else if (all_seen)   st_q <= ST_COUNT_ALL;
         else                 st_q <= ST_COUNT_ANY;
      end
   end

   assign state_o   = st_q;
   assign aligned_o = (st_q == ST_ALIGNED);

endmodule

// File: rtl/lane_deskew_group.sv
module lane_deskew_group
   import lane_deskew_pkg::*;
#(
   parameter int NUM_QUADS      = 2,
   parameter int LANES_PER_QUAD = 4,
   parameter int CNT_INIT       = 18,
   localparam int NUM_LANES     = NUM_QUADS * LANES_PER_QUAD,
   localparam int IDX_W         = $clog2(NUM_LANES)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LANES-1:0] marker_in,
   input  logic [NUM_LANES-1:0] lane_en,
   input  logic [1:0]           group_mode,
   input  logic                 resync_tgl,
   output logic [NUM_LANES-1:0] lane_rd_en,
   output logic                 all_aligned
);

   if (LANES_PER_QUAD < 2 || (LANES_PER_QUAD % 2) != 0) begin : g_bad_quad
      $error("LANES_PER_QUAD must be even and at least 2");
   end
   if (NUM_LANES < 2) begin : g_bad_lanes
      $error("at least two lanes are required");
   end
   if (CNT_INIT < 2) begin : g_bad_cnt
      $error("CNT_INIT must be at least 2");
   end

   logic                                rs_q;
   logic                                restart;
   grp_mode_e                           mode_q;
   grp_mode_e                           mode_eff;
   logic [NUM_LANES-1:0]                seen;
   logic [NUM_LANES-1:0][IDX_W-1:0]     lane_grp;
   logic [NUM_LANES-1:0][NUM_LANES-1:0] grp_members;
   logic [NUM_LANES-1:0]                grp_aligned;
   logic [NUM_LANES-1:0]                grp_idle;
   logic                                all_idle;

   // Resync is a toggle: any level change restarts every group.
   always_ff @(posedge clk) begin
      if (!rst_n) rs_q <= 1'b0;
      else        rs_q <= resync_tgl;
   end
   assign restart = (resync_tgl != rs_q);

   // Grouping is frozen as soon as any group leaves idle.
   assign all_idle = &grp_idle;
   assign mode_eff = all_idle ? grp_mode_e'(group_mode) : mode_q;

   always_ff @(posedge clk) begin
      if (!rst_n) mode_q <= GRP_SINGLE;
      else        mode_q <= mode_eff;
   end

   dsk_marker_latch #(.NUM_LANES(NUM_LANES)) u_latch (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart   (restart),
      .marker_in (marker_in),
      .lane_en   (lane_en),
      .seen_q    (seen)
   );

   dsk_group_map #(
      .NUM_LANES      (NUM_LANES),
      .LANES_PER_QUAD (LANES_PER_QUAD)
   ) u_map (
      .mode        (mode_eff),
      .lane_en     (lane_en),
      .lane_grp    (lane_grp),
      .grp_members (grp_members)
   );

   for (genvar g = 0; g < NUM_LANES; g++) begin : g_grp
      dsk_state_e st;
      dsk_group_ctrl #(
         .NUM_LANES (NUM_LANES),
         .CNT_INIT  (CNT_INIT)
      ) u_ctrl (
         .clk       (clk),
         .rst_n     (rst_n),
         .restart   (restart),
         .members   (grp_members[g]),
         .seen      (seen),
         .state_o   (st),
         .aligned_o (grp_aligned[g])
      );
      assign grp_idle[g] = (st == ST_IDLE);
   end

   for (genvar l = 0; l < NUM_LANES; l++) begin : g_rd
      assign lane_rd_en[l] = grp_aligned[lane_grp[l]] & lane_en[l];
   end

   assign all_aligned = (|lane_en) && (&(grp_aligned[lane_grp[0]] | ~lane_en[0]
                        ? (lane_rd_en | ~lane_en) : '0));

endmodule

// File: rtl/lane_deskew_group_chk.sv
module lane_deskew_group_chk #(
   parameter int NUM_LANES = 8,
   parameter int CNT_INIT  = 18
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 resync_tgl,
   input logic [NUM_LANES-1:0] lane_en,
   input logic [NUM_LANES-1:0] lane_rd_en,
   input logic                 all_aligned
);

   localparam int MIN_GAP = CNT_INIT / 2;

   logic       rs_seen;
   logic [7:0] since_start;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rs_seen     <= 1'b0;
         since_start <= '0;
      end else begin
         rs_seen <= resync_tgl;
         if (resync_tgl != rs_seen)  since_start <= '0;
         else if (since_start != '1) since_start <= since_start + 8'd1;
      end
   end

   // R8: a resync edge clears every read enable on the next sample
   assert_resync_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (resync_tgl != $past(resync_tgl)) |=> (lane_rd_en == '0));

   // R7: an enable stays high while its lane stays enabled and no resync comes
   for (genvar i = 0; i < NUM_LANES; i++) begin : g_sticky
      assert_enable_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (lane_rd_en[i] && lane_en[i] && resync_tgl == $past(resync_tgl))
         |=> (lane_rd_en[i] || !lane_en[i]));
   end

   // R2: no enable can rise before the shortest possible countdown has elapsed
   assert_min_countdown_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (|(lane_rd_en & ~$past(lane_rd_en) & $past(lane_en)))
      |-> (since_start >= 8'(MIN_GAP)));

   // R10: the common status implies every enabled lane is reading
   assert_all_aligned_R10: assert property (@(posedge clk) disable iff (!rst_n)
      all_aligned |-> ((lane_rd_en == lane_en) && (lane_en != '0)));

endmodule

bind lane_deskew_group lane_deskew_group_chk #(
   .NUM_LANES (NUM_LANES),
   .CNT_INIT  (CNT_INIT)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .resync_tgl  (resync_tgl),
   .lane_en     (lane_en),
   .lane_rd_en  (lane_rd_en),
   .all_aligned (all_aligned)
);

// File: tb/lane_deskew_group_bench.sv
`timescale 1ns/1ps
module lane_deskew_group_bench;

   localparam int NL = 8;
   typedef int off_t [NL];
   typedef struct {
      logic [NL-1:0] mask;
      int            cyc;
      string         tag;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NL-1:0] marker_in = '0;
   logic [NL-1:0] lane_en = '1;
   logic [1:0]    group_mode = 2'd0;
   logic          resync_tgl = 1'b0;
   logic [NL-1:0] lane_rd_en;
   logic          all_aligned;

   int   n_chk = 0;
   int   n_fail = 0;
   int   cyc = 0;
   exp_t sb_q[$];
   logic [NL-1:0] prev_rd = '0;
   bit   done = 0;

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   lane_deskew_group u_lane_deskew_group (
      .clk         (clk),
      .rst_n       (rst_n),
      .marker_in   (marker_in),
      .lane_en     (lane_en),
      .group_mode  (group_mode),
      .resync_tgl  (resync_tgl),
      .lane_rd_en  (lane_rd_en),
      .all_aligned (all_aligned)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   // Edges from the first latched marker to the rising enable, from R2/R3.
   function automatic int exp_delay(int gap);
      int n = 18;
      int t = 0;
      while (n > 0) begin
         int step;
         t++;
         step = (gap <= t - 1) ? 2 : 1;
         n = (n > step) ? n - step : 0;
      end
      return t;
   endfunction

   // Scoreboard monitor: every rising enable pattern must match the queue head.
   always @(negedge clk) begin
      if (rst_n) begin
         logic [NL-1:0] rise;
         rise = lane_rd_en & ~prev_rd;
         if (rise != '0) begin
            if (sb_q.size() == 0) begin
               check(1'b0, "R7 unexpected enable", int'(rise), 0);
            end else begin
               exp_t e;
               e = sb_q.pop_front();
               check(rise == e.mask, e.tag, int'(rise), int'(e.mask));
               check(cyc == e.cyc, e.tag, cyc, e.cyc);
            end
         end
      end
      prev_rd = lane_rd_en;
   end

   // Driver: pulses markers at given offsets (-1 = none), queues expectation.
   task automatic run_case(input off_t offs, input logic [NL-1:0] exp_mask,
                           input string tag);
      int first = 99;
      int last = -1;
      int maxo = -1;
      int c_first = 0;
      exp_t e;
      for (int l = 0; l < NL; l++) begin
         if (offs[l] > maxo) maxo = offs[l];
         if (exp_mask[l] && offs[l] >= 0) begin
            if (offs[l] < first) first = offs[l];
            if (offs[l] > last)  last = offs[l];
         end
      end
      for (int t = 0; t <= maxo; t++) begin
         @(negedge clk);
         for (int l = 0; l < NL; l++) marker_in[l] = (offs[l] == t);
         if (t == first) c_first = cyc + 1;
      end
      @(negedge clk);
      marker_in = '0;
      if (exp_mask != '0) begin
         e.mask = exp_mask;
         e.cyc  = c_first + exp_delay(last - first);
         e.tag  = tag;
         sb_q.push_back(e);
      end
   endtask

   task automatic wait_empty(input string tag);
      int n = 0;
      while (sb_q.size() != 0 && n < 40) begin
         @(negedge clk);
         n++;
      end
      check(sb_q.size() == 0, tag, sb_q.size(), 0);
      sb_q.delete();
   endtask

   task automatic do_resync();
      @(negedge clk);
      resync_tgl = ~resync_tgl;
      @(negedge clk);
      check(lane_rd_en == '0, "R8 resync clears", int'(lane_rd_en), 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check(lane_rd_en == '0, "R1 reset rd", int'(lane_rd_en), 0);
      check(all_aligned == 1'b0, "R1 reset aligned", all_aligned, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(lane_rd_en == '0, "R1 after reset", int'(lane_rd_en), 0);

      // R2: single lane counts down alone
      run_case('{0, -1, -1, -1, -1, -1, -1, -1}, 8'h01, "R2 single lane");
      wait_empty("R2 done");
      check(all_aligned == 1'b0, "R10 partial", all_aligned, 0);

      // R7: a second marker after alignment changes nothing
      run_case('{0, -1, -1, -1, -1, -1, -1, -1}, 8'h00, "R7");
      repeat (25) @(negedge clk);
      check(lane_rd_en == 8'h01, "R7 stays aligned", int'(lane_rd_en), 1);

      // R9: mode change while aligned is deferred; lane 1 still single
      group_mode = 2'd3;
      run_case('{-1, 0, -1, -1, -1, -1, -1, -1}, 8'h02, "R9 deferred mode");
      wait_empty("R9 done");

      do_resync();

      // R3/R5: pair 2+3, lane 3 early, odd countdown saturates
      group_mode = 2'd1;
      run_case('{-1, -1, 3, 0, -1, -1, -1, -1}, 8'h0C, "R3 pair saturate");
      wait_empty("R3 done");
      check(lane_rd_en[1:0] == 2'b00, "R4 pair isolation", int'(lane_rd_en), 12);

      do_resync();

      // R6: quad 4..7 with lane 6 disabled; its early marker is ignored
      lane_en = 8'hBF;
      group_mode = 2'd2;
      run_case('{-1, -1, -1, -1, 2, 3, 0, 4}, 8'hB0, "R6 quad disabled lane");
      wait_empty("R6 done");
      check(lane_rd_en[6] == 1'b0, "R6 disabled rd", lane_rd_en[6], 0);

      do_resync();

      // R6: disabled lane alone never aligns
      group_mode = 2'd0;
      lane_en = 8'hF7;
      run_case('{-1, -1, -1, 0, -1, -1, -1, -1}, 8'h00, "R6");
      repeat (25) @(negedge clk);
      check(lane_rd_en == '0, "R6 no enable", int'(lane_rd_en), 0);

      do_resync();

      // R4/R10: all eight lanes in one group
      lane_en = 8'hFF;
      group_mode = 2'd3;
      run_case('{3, 0, 7, 5, 1, 6, 2, 4}, 8'hFF, "R4 octal group");
      wait_empty("R4 done");
      check(all_aligned == 1'b1, "R10 all aligned", all_aligned, 1);

      do_resync();
      check(all_aligned == 1'b0, "R10 after resync", all_aligned, 0);

      done = 1;
      finish_run();
   end

endmodule